// File: doc/BRIEF.md
# One-Wire Search Triplet Unit

This block carries out one branch step of a one-wire ROM search. After a start pulse it asks a bit-slot engine for two read slots. The first returns the id bit and the second returns its complement. From the two values it picks a branch direction and asks for one more slot that writes that direction onto the bus. It then reports a 3-bit status.

If both read slots return 1, no device answered, so the unit skips the write and reports the error code at once. When both reads return 0, devices disagree at this bit position. In that case the caller's preferred direction decides the branch.

The unit talks to the slot engine through a simple handshake. The unit raises `slot_req` for one cycle and `slot_bit` gives the level of that slot: 1 for a read slot, or the bit to write. The engine answers later with a one-cycle `slot_done`, and for read slots it also drives the sampled bus level on `slot_rd`.

Top module: `ow_triplet`

## Requirements
- R1: After a start is accepted, the unit issues slot requests in this order: a read slot (`slot_bit`=1) for the id bit, a read slot (`slot_bit`=1) for the complement, and then a write slot whose `slot_bit` is the chosen direction. Each request follows the `slot_done` of the previous slot by exactly one cycle.
- R2: The status layout is: bit 0 holds the id bit, bit 1 holds the complement bit, and bit 2 holds the direction taken.
- R3: If both reads return 1, the status becomes 3'b011, `done` pulses in the cycle after the second `slot_done`, and no write slot is requested.
- R4: If both reads return 0, the direction is the value of `pref_dir` captured when the start was accepted. The status is 3'b100 for a direction of 1 and 3'b000 for a direction of 0.
- R5: If exactly one read returns 1, the direction equals the id bit. The status is 3'b101 when the id bit is 1 and 3'b010 when it is 0.
- R6: `done` is high for exactly one cycle, in the cycle after the `slot_done` of the write slot. `status` changes only together with a `done` pulse and holds its value between pulses.
- R7: A `start` that arrives while `busy` is high is ignored. It changes neither the slot sequence nor the direction that is chosen.
- R8: `slot_req` is never high for two cycles in a row. The engine must answer at least one cycle after the request. A `slot_done` that arrives while no slot is outstanding has no effect.
- R9: During and after reset, `busy`, `slot_req` and `done` are 0 and `status` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start one triplet (accepted when idle) |
| pref_dir | input | 1 | Direction to take when both reads return 0 |
| busy | output | 1 | A triplet is in progress |
| slot_req | output | 1 | One-cycle request for a bus slot |
| slot_bit | output | 1 | Level of the requested slot (1 = read/touch-1) |
| slot_done | input | 1 | Slot engine finished the current slot |
| slot_rd | input | 1 | Bus level sampled in a read slot, valid with slot_done |
| done | output | 1 | One-cycle pulse: status valid |
| status | output | 3 | {direction, complement bit, id bit} |

## Verification
Each result is due a fixed number of cycles after its cause. A slot request appears in the cycle after the accepting start or after the previous `slot_done`. `done` and the new status appear in the cycle after the final `slot_done`: the second one in the error case, the third one otherwise.

The bench predicts `slot_req`, `slot_bit`, `done`, `status` and `busy` for every cycle and compares them in the middle of the cycle. Expected values come from the status rules, taken one case at a time. The bench varies the engine latency so that a check made in the wrong cycle cannot pass.

// File: rtl/ow_triplet.sv
`timescale 1ns/1ps
module ow_triplet (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pref_dir,
  output logic       busy,
  output logic       slot_req,
  output logic       slot_bit,
  input  logic       slot_done,
  input  logic       slot_rd,
  output logic       done,
  output logic [2:0] status
);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ_ID, S_WAIT_ID, S_REQ_CMP, S_WAIT_CMP, S_REQ_WR, S_WAIT_WR
  } state_t;

  state_t     st;
  logic       id_q, cmp_q, pref_q, dir_q, done_q;
  logic [2:0] status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      id_q     <= 1'b0;
      cmp_q    <= 1'b0;
      pref_q   <= 1'b0;
      dir_q    <= 1'b0;
      done_q   <= 1'b0;
      status_q <= 3'b000;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            pref_q <= pref_dir;
            st     <= S_REQ_ID;
          end
        S_REQ_ID:  st <= S_WAIT_ID;
        S_WAIT_ID:
          if (slot_done) begin
            id_q <= slot_rd;
            st   <= S_REQ_CMP;
          end
        S_REQ_CMP: st <= S_WAIT_CMP;
        S_WAIT_CMP:
          if (slot_done) begin
            cmp_q <= slot_rd;
            if (id_q && slot_rd) begin
              status_q <= 3'b011;
              done_q   <= 1'b1;
              st       <= S_IDLE;
            end else begin
              dir_q <= (id_q ^ slot_rd) ? id_q : pref_q;
              st    <= S_REQ_WR;
            end
          end
        S_REQ_WR:  st <= S_WAIT_WR;
        S_WAIT_WR:
          if (slot_done) begin
            status_q <= {dir_q, cmp_q, id_q};
            done_q   <= 1'b1;
            st       <= S_IDLE;
          end
        default:   st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign slot_req = (st == S_REQ_ID) || (st == S_REQ_CMP) || (st == S_REQ_WR);
  assign slot_bit = (st == S_REQ_WR) ? dir_q : 1'b1;
  assign done     = done_q;
  assign status   = status_q;

endmodule

// File: rtl/ow_triplet_chk.sv
`timescale 1ns/1ps
module ow_triplet_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       slot_req,
  input logic       done,
  input logic [2:0] status
);

  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req |=> !slot_req);

  assert_req_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req |-> busy);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(status) || done);

  assert_err_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[0] && status[1]) |-> !status[2]);

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 3'b001) && (status != 3'b110) && (status != 3'b111));

endmodule

bind ow_triplet ow_triplet_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .slot_req(slot_req),
  .done(done), .status(status)
);

// File: tb/ow_triplet_test.sv
`timescale 1ns/1ps
module ow_triplet_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, pref_dir = 1'b0, slot_done = 1'b0, slot_rd = 1'b0;
  logic busy, slot_req, slot_bit, done;
  logic [2:0] status;

  int tests = 0;
  int fails = 0;
  logic [2:0] exp_status = 3'b000;

  always #4 clk = ~clk;

  ow_triplet uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
    .busy(busy), .slot_req(slot_req), .slot_bit(slot_bit),
    .slot_done(slot_done), .slot_rd(slot_rd), .done(done), .status(status)
  );

  task automatic step(input logic er, input logic eb, input logic ed,
                      input logic ebusy, input string tag);
    @(negedge clk);
    tests++;
    if (slot_req !== er || (er && slot_bit !== eb) || done !== ed ||
        status !== exp_status || busy !== ebusy) begin
      fails++;
      $display("FAIL %s: req=%b bit=%b done=%b status=%b busy=%b expected req=%b bit=%b done=%b status=%b busy=%b",
               tag, slot_req, slot_bit, done, status, busy,
               er, eb, ed, exp_status, ebusy);
    end
  endtask

  task automatic triplet(input logic id, input logic cmp, input logic pref,
                         input int lat, input bit poke);
    logic err, dir;
    logic [2:0] code;
    err = id & cmp;
    if (!id && !cmp) begin dir = pref; code = pref ? 3'b100 : 3'b000; end
    else if (id ^ cmp) begin dir = id; code = id ? 3'b101 : 3'b010; end
    else begin dir = 1'b0; code = 3'b011; end
    start = 1'b1; pref_dir = pref;
    step(1, 1, 0, 1, "R1 id read request");
    start = 1'b0;
    for (int i = 0; i < lat; i++) begin
      if (poke && i == 0) begin start = 1'b1; pref_dir = ~pref; end
      step(0, 0, 0, 1, "R7 wait id slot");
      start = 1'b0;
    end
    slot_done = 1'b1; slot_rd = id;
    step(1, 1, 0, 1, "R1 complement read request");
    slot_done = 1'b0;
    for (int i = 0; i < lat; i++) begin
      if (poke && i == 0) begin start = 1'b1; pref_dir = ~pref; end
      step(0, 0, 0, 1, "R8 wait complement slot");
      start = 1'b0;
    end
    slot_done = 1'b1; slot_rd = cmp;
    if (err) begin
      exp_status = code;
      step(0, 0, 1, 0, "R3 error done without write");
      slot_done = 1'b0;
    end else begin
      step(1, dir, 0, 1, "R4 R5 direction write request");
      slot_done = 1'b0;
      for (int i = 0; i < lat; i++) step(0, 0, 0, 1, "R6 wait write slot");
      slot_done = 1'b1; slot_rd = ~dir;
      exp_status = code;
      step(0, 0, 1, 0, "R2 R6 done with status");
      slot_done = 1'b0;
    end
    step(0, 0, 0, 0, "R6 done single cycle status held");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(0, 0, 0, 0, "R9 in reset");
    step(0, 0, 0, 0, "R9 in reset");
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R9 after reset");
    slot_done = 1'b1; slot_rd = 1'b1;
    step(0, 0, 0, 0, "R8 stray done ignored");
    slot_done = 1'b0;
    triplet(0, 0, 1, 1, 0);
    triplet(0, 0, 0, 3, 0);
    triplet(1, 0, 0, 2, 0);
    triplet(0, 1, 1, 1, 0);
    triplet(1, 1, 0, 4, 0);
    triplet(0, 0, 1, 2, 1);
    triplet(0, 0, 0, 5, 1);
    triplet(1, 0, 1, 3, 1);
    triplet(1, 1, 1, 1, 1);
    for (int k = 0; k < 24; k++)
      triplet(k[0], k[1], k[2], 1 + (k % 4), k[3]);
    slot_done = 1'b1; slot_rd = 1'b0;
    step(0, 0, 0, 0, "R8 stray done after runs");
    slot_done = 1'b0;
    step(0, 0, 0, 0, "R6 status held idle");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule